// File: doc/BRIEF.md
# Asynchronous SRAM write sequencer

This block turns single write requests from a synchronous host into correctly timed write cycles on an external asynchronous static RAM. The RAM has an active-low chip select, an active-high chip select, an active-low write enable and an active-low output enable. The block drives these pins, the address bus and the output data bus. It also drives the enable for its own tri-state data driver. Every timing interval of the memory is a parameter counted in clock cycles: address setup, write pulse width, data setup, data hold, write recovery and the time the memory needs to release its outputs.

The host places an address, a data byte and an output-enable choice on the request inputs. It raises `req` while `ready` is high. The block captures the request and lowers `ready`. It then runs address setup, the write pulse, data hold and recovery, and raises `ready` again. Requests made while `ready` is low have no effect.

When the host asks for the output enable to stay low during the write, the memory may still be driving the shared bus when write enable falls. The block therefore keeps its own driver off for a release interval at the start of the write pulse. It also lengthens the pulse so that the full data setup still fits after the release interval.

Top module: `sram_wr_seq`

## Requirements
- R1: While reset is held, and in every idle cycle, `ready`=1, `sram_we_n`=1, `sram_cs1_n`=1, `sram_cs2`=0 and `sram_dout_en`=0. Reset also sets `sram_oe_n`=1 and clears `sram_addr` and `sram_dout` to 0.
- R2: A request is accepted on a rising clock edge where `req`=1 and `ready`=1. After that edge, `ready`=0, `sram_addr` and `sram_dout` hold the captured address and data, both chip selects are asserted (`sram_cs1_n`=0, `sram_cs2`=1) and `sram_we_n`=1. A request made while `ready`=0 changes no output.
- R3: `sram_we_n` falls exactly T_AS cycles after the chip selects assert.
- R4: With `req_oe_low`=0 captured, `sram_we_n` stays low for max(T_WP,T_DW) cycles and `sram_dout_en`=1 for that whole pulse.
- R5: With `req_oe_low`=1 captured, `sram_dout_en` stays 0 for the first T_WHZ cycles of the write pulse. The pulse then continues with `sram_dout_en`=1 for max(T_DW, T_WP−T_WHZ, 1) cycles, so the pulse totals at least T_WHZ+T_DW cycles.
- R6: Both chip selects stay asserted in every cycle in which `sram_we_n`=0. `sram_addr` does not change while `sram_cs1_n`=0, `sram_cs2`=1 and `sram_we_n`=0 hold together.
- R7: On the edge where `sram_we_n` rises, the chip selects deassert. `sram_dout_en` stays 1, with `sram_dout` unchanged, for T_DH cycles.
- R8: After the hold, T_WR cycles of recovery pass with all strobes inactive and `ready`=0. `ready` then returns to 1.
- R9: `sram_oe_n` is the inverse of the `req_oe_low` value captured at acceptance. It keeps that value until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Write request |
| req_addr | input | 17 | Write address |
| req_data | input | 8 | Write data |
| req_oe_low | input | 1 | Hold output enable low during this write |
| ready | output | 1 | Idle and able to accept a request |
| sram_addr | output | 17 | Memory address bus |
| sram_dout | output | 8 | Data to the memory bus |
| sram_dout_en | output | 1 | Enable for the data-bus driver |
| sram_cs1_n | output | 1 | Active-low chip select |
| sram_cs2 | output | 1 | Active-high chip select |
| sram_we_n | output | 1 | Active-low write enable |
| sram_oe_n | output | 1 | Active-low output enable |

## Verification
The assertions assume that the host inputs change only between clock edges. They also assume that the timing parameters are all at least one, so every phase lasts at least a cycle and the write pulse always follows a setup cycle. The stimulus drives every input on the falling clock edge. It keeps the parameters at their defaults and holds `req` high through busy periods with changing address and data, so requests that must be ignored are exercised without breaking the input assumptions.

// File: rtl/sram_wr_pkg.sv
// Package: shared phase encoding and a helper for the write sequencer.
// Assumes: included first in the compile order.
package sram_wr_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SETUP = 3'd1,
        PH_REL   = 3'd2,
        PH_DRIVE = 3'd3,
        PH_HOLD  = 3'd4,
        PH_REC   = 3'd5
    } wr_phase_t;

    // Larger of two integer timing values.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_wr_timer.sv
// Phase timer: a down counter loaded at each phase entry.
// Assumes: load values are phase length minus one; expired flags the last cycle.
module sram_wr_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    // Count down to zero, or reload on phase entry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_wr_fsm.sv
// Phase sequencer: walks setup, release, drive, hold and recovery.
// Assumes: all phase lengths >= 1; the timer expires on each phase's last cycle.
module sram_wr_fsm
    import sram_wr_pkg::*;
#(
    parameter int CNT_W  = 3,
    parameter int LEN_AS = 2,
    parameter int LEN_RL = 2,
    parameter int LEN_HI = 4,
    parameter int LEN_LO = 3,
    parameter int LEN_DH = 1,
    parameter int LEN_WR = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             req_oe_low,
    input  logic             expired,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output logic             accept,
    output wr_phase_t        phase_d
);
    wr_phase_t phase_q;
    logic      oe_low_q;

    assign accept = (phase_q == PH_IDLE) && req;

    // Next phase and timer reload value.
    always_comb begin
        phase_d  = phase_q;
        load     = 1'b0;
        load_val = '0;
        case (phase_q)
            PH_IDLE: if (req) begin
                phase_d = PH_SETUP; load = 1'b1; load_val = CNT_W'(LEN_AS - 1);
            end
            PH_SETUP: if (expired) begin
                load = 1'b1;
                if (oe_low_q) begin
                    phase_d = PH_REL;   load_val = CNT_W'(LEN_RL - 1);
                end else begin
                    phase_d = PH_DRIVE; load_val = CNT_W'(LEN_HI - 1);
                end
            end
            PH_REL: if (expired) begin
                phase_d = PH_DRIVE; load = 1'b1; load_val = CNT_W'(LEN_LO - 1);
            end
            PH_DRIVE: if (expired) begin
                phase_d = PH_HOLD; load = 1'b1; load_val = CNT_W'(LEN_DH - 1);
            end
            PH_HOLD: if (expired) begin
                phase_d = PH_REC; load = 1'b1; load_val = CNT_W'(LEN_WR - 1);
            end
            PH_REC: if (expired) phase_d = PH_IDLE;
            default: phase_d = PH_IDLE;
        endcase
    end

    // Phase register and captured output-enable mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_IDLE;
            oe_low_q <= 1'b0;
        end else begin
            phase_q <= phase_d;
            if (accept) oe_low_q <= req_oe_low;
        end
    end
endmodule

// File: rtl/sram_wr_pins.sv
// Pin register: registers every memory pin from the next phase, so strobes are glitch-free.
// Assumes: accept is high only in the idle cycle that starts a write.
module sram_wr_pins
    import sram_wr_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              req_oe_low,
    input  wr_phase_t         phase_d,
    output logic              ready,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dout,
    output logic              sram_dout_en,
    output logic              sram_cs1_n,
    output logic              sram_cs2,
    output logic              sram_we_n,
    output logic              sram_oe_n
);
    logic sel_d, we_d, drv_d;

    // Decode the strobes for the coming phase.
    always_comb begin
        sel_d = (phase_d == PH_SETUP) || (phase_d == PH_REL) || (phase_d == PH_DRIVE);
        we_d  = (phase_d == PH_REL)   || (phase_d == PH_DRIVE);
        drv_d = (phase_d == PH_DRIVE) || (phase_d == PH_HOLD);
    end

    // Strobe and handshake flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready        <= 1'b1;
            sram_cs1_n   <= 1'b1;
            sram_cs2     <= 1'b0;
            sram_we_n    <= 1'b1;
            sram_dout_en <= 1'b0;
        end else begin
            ready        <= (phase_d == PH_IDLE);
            sram_cs1_n   <= ~sel_d;
            sram_cs2     <= sel_d;
            sram_we_n    <= ~we_d;
            sram_dout_en <= drv_d;
        end
    end

    // Address, data and output-enable capture at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sram_addr <= '0;
            sram_dout <= '0;
            sram_oe_n <= 1'b1;
        end else if (accept) begin
            sram_addr <= req_addr;
            sram_dout <= req_data;
            sram_oe_n <= ~req_oe_low;
        end
    end
endmodule

// File: rtl/sram_wr_seq.sv
// Top: asynchronous SRAM write sequencer with request/ready host side.
// Assumes: all timing parameters are >= 1 and given in clock cycles.
module sram_wr_seq
    import sram_wr_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8,
    parameter int T_AS   = 2,
    parameter int T_WP   = 4,
    parameter int T_DW   = 3,
    parameter int T_DH   = 1,
    parameter int T_WR   = 2,
    parameter int T_WHZ  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              req_oe_low,
    output logic              ready,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dout,
    output logic              sram_dout_en,
    output logic              sram_cs1_n,
    output logic              sram_cs2,
    output logic              sram_we_n,
    output logic              sram_oe_n
);
    localparam int LEN_HI  = imax(T_WP, T_DW);
    localparam int WP_REST = (T_WP > T_WHZ) ? (T_WP - T_WHZ) : 1;
    localparam int LEN_LO  = imax(T_DW, WP_REST);
    localparam int LEN_MAX = imax(imax(imax(T_AS, T_WHZ), imax(LEN_HI, LEN_LO)),
                                  imax(T_DH, T_WR));
    localparam int CNT_W   = $clog2(LEN_MAX + 1);

    logic             load, expired, accept;
    logic [CNT_W-1:0] load_val;
    wr_phase_t        phase_d;

    sram_wr_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .expired(expired)
    );

    sram_wr_fsm #(
        .CNT_W(CNT_W), .LEN_AS(T_AS), .LEN_RL(T_WHZ), .LEN_HI(LEN_HI),
        .LEN_LO(LEN_LO), .LEN_DH(T_DH), .LEN_WR(T_WR)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .req(req), .req_oe_low(req_oe_low),
        .expired(expired), .load(load), .load_val(load_val),
        .accept(accept), .phase_d(phase_d)
    );

    sram_wr_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .clk(clk), .rst_n(rst_n), .accept(accept), .req_addr(req_addr),
        .req_data(req_data), .req_oe_low(req_oe_low), .phase_d(phase_d),
        .ready(ready), .sram_addr(sram_addr), .sram_dout(sram_dout),
        .sram_dout_en(sram_dout_en), .sram_cs1_n(sram_cs1_n), .sram_cs2(sram_cs2),
        .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n)
    );
endmodule

// File: rtl/sram_wr_seq_chk.sv
// Checker: pin-level protocol properties of the write sequencer, bound to the top.
// Assumes: inputs change only between clock edges.
module sram_wr_seq_chk #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              ready,
    input logic [ADDR_W-1:0] sram_addr,
    input logic [DATA_W-1:0] sram_dout,
    input logic              sram_dout_en,
    input logic              sram_cs1_n,
    input logic              sram_cs2,
    input logic              sram_we_n
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (sram_we_n && sram_cs1_n && !sram_cs2 && !sram_dout_en)); // R1
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ready) |=> (!ready && !sram_cs1_n && sram_cs2 && sram_we_n)); // R2
    AST_WE_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_we_n) |-> $past(!sram_cs1_n && sram_cs2 && sram_we_n)); // R3
    AST_CS_COVERS_WE: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (!sram_cs1_n && sram_cs2)); // R6
    AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_we_n && !sram_cs1_n && sram_cs2) |-> $stable(sram_addr)); // R6
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (sram_dout_en && $stable(sram_dout) && sram_cs1_n && !sram_cs2)); // R7
    AST_READY_AFTER_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(sram_we_n && sram_cs1_n && !sram_dout_en)); // R8
endmodule

bind sram_wr_seq sram_wr_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req(req), .ready(ready), .sram_addr(sram_addr),
    .sram_dout(sram_dout), .sram_dout_en(sram_dout_en), .sram_cs1_n(sram_cs1_n),
    .sram_cs2(sram_cs2), .sram_we_n(sram_we_n)
);

// File: tb/sram_wr_seq_bench.sv
// Bench: behavioural reference model of the pin timeline, compared every cycle.
module sram_wr_seq_bench;
    localparam int AS = 2, WP = 4, DW = 3, DH = 1, WR = 2, WHZ = 2;
    localparam int HI = (WP > DW) ? WP : DW;
    localparam int LO = (DW > ((WP > WHZ) ? WP - WHZ : 1)) ? DW : ((WP > WHZ) ? WP - WHZ : 1);

    logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, req_oe_low = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_data = '0;
    logic ready, dout_en, cs1_n, cs2, we_n, oe_n;
    logic [16:0] addr;
    logic [7:0]  dout;

    int checks = 0, errors = 0, cyc = 0;
    bit cmp_on = 0, done = 0;

    // reference model state
    bit busy = 0, m_oe = 0;
    int t = 0;
    logic [16:0] m_addr = '0;
    logic [7:0]  m_data = '0;

    always #5 clk = ~clk;

    sram_wr_seq u_sram_wr_seq (
        .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr), .req_data(req_data),
        .req_oe_low(req_oe_low), .ready(ready), .sram_addr(addr), .sram_dout(dout),
        .sram_dout_en(dout_en), .sram_cs1_n(cs1_n), .sram_cs2(cs2), .sram_we_n(we_n),
        .sram_oe_n(oe_n)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", tag, what, act, exp, cyc);
        end
    endtask

    function automatic int total_len(input bit oe);
        return AS + (oe ? WHZ + LO : HI) + DH + WR;
    endfunction

    // Model update on each edge.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            busy = 0; m_oe = 0; m_addr = '0; m_data = '0; t = 0;
        end else if (!busy) begin
            if (req) begin
                busy = 1; t = 0; m_addr = req_addr; m_data = req_data; m_oe = req_oe_low;
            end
        end else if (t == total_len(m_oe) - 1) begin
            busy = 0;
        end else begin
            t++;
        end
    end

    // Compare DUT pins with the model between edges.
    always @(negedge clk) begin
        if (cmp_on) begin
            int wlo_start, wlo_len, drv_start, hold_start;
            bit e_sel, e_we, e_drv;
            wlo_start  = AS;
            wlo_len    = m_oe ? WHZ + LO : HI;
            drv_start  = m_oe ? AS + WHZ : AS;
            hold_start = AS + wlo_len;
            e_sel = busy && (t < hold_start);
            e_we  = busy && (t >= wlo_start) && (t < hold_start);
            e_drv = busy && (t >= drv_start) && (t < hold_start + DH);
            check(busy ? "R8" : "R1", "ready", ready, !busy);
            check(m_oe ? "R5" : "R4", "we_n", we_n, !e_we);
            check(e_we ? "R6" : "R3", "cs1_n", cs1_n, !e_sel);
            check(e_we ? "R6" : "R2", "cs2", cs2, e_sel);
            check(m_oe ? "R5" : "R7", "dout_en", dout_en, e_drv);
            check("R2", "addr", addr, m_addr);
            check("R7", "dout", dout, m_data);
            check("R9", "oe_n", oe_n, !m_oe);
        end
    end

    task automatic wr(input logic [16:0] a, input logic [7:0] d, input bit oe);
        while (!ready) @(negedge clk);
        req = 1; req_addr = a; req_data = d; req_oe_low = oe;
        @(negedge clk);
        req = 0; req_addr = ~a; req_data = ~d;
        while (!ready) @(negedge clk);
    endtask

    // Watchdog.
    always @(posedge clk) begin
        if (cyc > 20000 && !done) begin
            checks++; errors++;
            $display("FAIL R8 watchdog expired actual=busy expected=idle");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "reset ready", ready, 1);
        check("R1", "reset we_n", we_n, 1);
        check("R1", "reset cs1_n", cs1_n, 1);
        check("R1", "reset cs2", cs2, 0);
        check("R1", "reset dout_en", dout_en, 0);
        check("R1", "reset oe_n", oe_n, 1);
        check("R1", "reset addr", addr, 0);
        rst_n = 1;
        cmp_on = 1;
        @(negedge clk);
        // R4 output enable high, R5 output enable low, boundary addresses and data
        wr(17'h1FFFF, 8'hFF, 0);
        wr(17'h00000, 8'h00, 1);
        wr(17'h0A5A5, 8'h3C, 1);
        wr(17'h15A5A, 8'hC3, 0);
        // R2 request held high through busy: back-to-back, changing fields ignored
        for (int i = 0; i < 60; i++) begin
            req = 1; req_addr = 17'(i * 977); req_data = 8'(i * 31); req_oe_low = i[2];
            @(negedge clk);
        end
        req = 0;
        // mixed pattern
        for (int i = 0; i < 600; i++) begin
            req = ($urandom % 3) != 0;
            req_addr = 17'($urandom);
            req_data = 8'($urandom);
            req_oe_low = $urandom % 2;
            @(negedge clk);
        end
        req = 0;
        while (!ready) @(negedge clk);
        repeat (3) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule